// File: doc/BRIEF.md
# Read prefetch length controller

This block sizes the upstream read request that a bridge issues when a downstream master starts a memory read on an interface running in conventional (non PCI-X) mode. It also decides when the downstream transfer is cut off. When a read is accepted, the block picks the prefetch policy that belongs to the command type. It combines that policy with the prefetchable-range hit flag, the cache line size and the maximum-length code. From these it produces one request byte count, pulsed for a single cycle.

A DWORD down-counter is loaded with the same length. Each delivered data beat decrements it. The disconnect output is raised on the beat that empties the counter. The block then returns to idle and accepts the next read. Address decoding, bus signalling and the data buffer sit outside the block. They supply the hit flag and the beat strobe and consume the request and the disconnect.

Top module: `rd_prefetch_sizer`

## Requirements
- R1: With a full-prefetch policy, the request length follows `max_sel`: 1→128, 2→256, 3→512, 4→1024, 5→2048, 6→4096 bytes, and both 0 and 7 give 512 bytes.
- R2: The policy is taken from the field belonging to the command code: `pol_mr` for 4'b0110 (memory read), `pol_mrl` for 4'b1110 (read line), `pol_mrm` for 4'b1100 (read multiple). Policy code 2'b00 means one cache line and 2'b10 means full prefetch.
- R3: Policy 2'b00 with a prefetchable hit requests `line_dw`×4 bytes. A `line_dw` of zero requests 4 bytes.
- R4: A miss on the prefetchable range, policy 2'b01 on any command, or policy 2'b11 on read line or read multiple requests 4 bytes.
- R5: Policy 2'b11 on a plain memory read requests 4 bytes, so the transfer disconnects after the first DWORD.
- R6: While `pcix_mode` is high, a start is ignored: no request is issued and `active` stays low.
- R7: An accepted start raises `req_valid` for exactly one cycle after the clock edge that samples it. `req_bytes` stays stable while `active` is high.
- R8: `stop` is high only in the cycle of the beat that takes the remaining DWORD count to zero. That is the (req_bytes/4)-th beat. `active` falls at the following edge.
- R9: A start carrying a non-read command, or arriving while `active` is high, is ignored and leaves the current transfer unchanged.
- R10: After reset, `req_valid`, `active` and `stop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | A downstream read begins this cycle |
| cmd | input | 4 | Bus command code of that read |
| pref_hit | input | 1 | Address lies in the prefetchable range |
| pcix_mode | input | 1 | Downstream interface runs in PCI-X mode |
| max_sel | input | 3 | Maximum full-prefetch length code |
| pol_mr | input | 2 | Policy for memory read |
| pol_mrl | input | 2 | Policy for read line |
| pol_mrm | input | 2 | Policy for read multiple |
| line_dw | input | CL_W | Cache line size in DWORDs |
| beat | input | 1 | One data DWORD delivered downstream |
| req_valid | output | 1 | One-cycle strobe of a new upstream request |
| req_bytes | output | CNT_W+2 | Requested byte count |
| active | output | 1 | A transfer is in progress |
| stop | output | 1 | Disconnect the downstream master on this beat |

## Verification
The request is registered, so `req_valid` and `req_bytes` are due one edge after the start is sampled. The bench drives a start at a falling edge and reads the request at the next falling edge. `stop` is combinational from the beat strobe and the counter. Each beat is therefore driven at a falling edge, and `stop` is sampled one time unit later in the same cycle. This is expected high only on the (req_bytes/4)-th beat. `active` is checked one falling edge after the last beat, and ignored starts are judged by the absence of `req_valid` and by an unchanged beat count.

// File: rtl/rd_prefetch_sizer.sv
module rd_prefetch_sizer #(
  parameter int CL_W  = 8,
  parameter int CNT_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [3:0]           cmd,
  input  logic                 pref_hit,
  input  logic                 pcix_mode,
  input  logic [2:0]           max_sel,
  input  logic [1:0]           pol_mr,
  input  logic [1:0]           pol_mrl,
  input  logic [1:0]           pol_mrm,
  input  logic [CL_W-1:0]      line_dw,
  input  logic                 beat,
  output logic                 req_valid,
  output logic [CNT_W+1:0]     req_bytes,
  output logic                 active,
  output logic                 stop
);
  localparam logic [3:0] CMD_MR  = 4'b0110;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [CNT_W-1:0] ONE_DW = CNT_W'(1);

  logic             is_mr, is_mrl, is_mrm, is_read, accept;
  logic [1:0]       pol;
  logic [CNT_W-1:0] full_dw, line_eff, want_dw, cnt;

  assign is_mr   = cmd == CMD_MR;
  assign is_mrl  = cmd == CMD_MRL;
  assign is_mrm  = cmd == CMD_MRM;
  assign is_read = is_mr | is_mrl | is_mrm;
  assign pol     = is_mr ? pol_mr : (is_mrl ? pol_mrl : pol_mrm);
  assign accept  = start & is_read & ~pcix_mode & ~active;

  always_comb begin
    case (max_sel)
      3'd1:    full_dw = CNT_W'(32);
      3'd2:    full_dw = CNT_W'(64);
      3'd4:    full_dw = CNT_W'(256);
      3'd5:    full_dw = CNT_W'(512);
      3'd6:    full_dw = CNT_W'(1024);
      default: full_dw = CNT_W'(128);
    endcase
  end

  assign line_eff = (line_dw == '0) ? ONE_DW : CNT_W'(line_dw);

  always_comb begin
    want_dw = ONE_DW;
    if (pref_hit) begin
      case (pol)
        2'b00:   want_dw = line_eff;
        2'b10:   want_dw = full_dw;
        default: want_dw = ONE_DW;
      endcase
    end
  end

  assign stop = active & beat & (cnt == ONE_DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active    <= 1'b0;
      req_valid <= 1'b0;
      req_bytes <= '0;
    end else begin
      req_valid <= accept;
      if (accept) begin
        cnt       <= want_dw;
        active    <= 1'b1;
        req_bytes <= {want_dw, 2'b00};
      end else if (active && beat) begin
        cnt <= cnt - ONE_DW;
        if (cnt == ONE_DW) active <= 1'b0;
      end
    end
  end
endmodule

module rd_prefetch_sizer_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pcix_mode,
  input logic             beat,
  input logic             req_valid,
  input logic [CNT_W+1:0] req_bytes,
  input logic             active,
  input logic             stop
);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  a_r7_req_opens: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> active);
  a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !req_valid) |-> $stable(req_bytes));
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes >= 4 && req_bytes <= 4096 && req_bytes[1:0] == 2'b00));
  a_r8_stop_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (beat && active));
  a_r8_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active);
  a_r6_pcix_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pcix_mode && start && !active) |=> !req_valid);
endmodule

bind rd_prefetch_sizer rd_prefetch_sizer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pcix_mode(pcix_mode), .beat(beat),
  .req_valid(req_valid), .req_bytes(req_bytes), .active(active), .stop(stop)
);

// File: tb/tb_rd_prefetch_sizer.sv
module tb_rd_prefetch_sizer;
  logic        clk = 0, rst_n = 0, start = 0, pref_hit = 1, pcix_mode = 0, beat = 0;
  logic [3:0]  cmd = 4'b0110;
  logic [2:0]  max_sel = 0;
  logic [1:0]  pol_mr = 0, pol_mrl = 0, pol_mrm = 2'b10;
  logic [7:0]  line_dw = 8;
  logic        req_valid, active, stop;
  logic [12:0] req_bytes;
  int checks = 0, fails = 0;

  localparam logic [3:0] MR = 4'b0110, MRL = 4'b1110, MRM = 4'b1100, MWR = 4'b0111;

  rd_prefetch_sizer dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int full_bytes(input int sel);
    if (sel >= 1 && sel <= 6) return 128 << (sel - 1);
    return 512;
  endfunction

  task automatic pulse_start(input logic [3:0] c);
    @(negedge clk); cmd = c; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_read(input logic [3:0] c, input int exp_bytes, input string req);
    int stops_ok = 1;
    pulse_start(c);
    chk({req, " req_valid"}, req_valid, 1);
    chk({req, " req_bytes"}, req_bytes, exp_bytes);
    for (int i = 0; i < exp_bytes / 4; i++) begin
      beat = 1; #1;
      if (stop !== (i == exp_bytes / 4 - 1)) stops_ok = 0;
      @(negedge clk);
    end
    beat = 0; #1;
    chk({req, " R8 stop only on last beat"}, stops_ok, 1);
    chk({req, " R8 active after last beat"}, active, 0);
  endtask

  task automatic t_reset;
    chk("R10 req_valid", req_valid, 0);
    chk("R10 active", active, 0);
    chk("R10 stop", stop, 0);
  endtask

  task automatic t_max_decode;
    pol_mrm = 2'b10; pref_hit = 1;
    for (int s = 0; s < 8; s++) begin
      max_sel = 3'(s);
      run_read(MRM, full_bytes(s), "R1");
    end
  endtask

  task automatic t_cmd_select;
    max_sel = 3'd2; line_dw = 8;
    pol_mr = 2'b00; pol_mrl = 2'b10; pol_mrm = 2'b00;
    run_read(MR, 32, "R2 mr");
    run_read(MRL, 256, "R2 mrl");
    pol_mr = 2'b10; pol_mrl = 2'b00; pol_mrm = 2'b10;
    run_read(MRL, 32, "R2 mrl line");
    run_read(MRM, 256, "R2 mrm");
    run_read(MR, 256, "R2 mr full");
  endtask

  task automatic t_line;
    pol_mr = 2'b00;
    line_dw = 16; run_read(MR, 64, "R3 line16");
    line_dw = 1;  run_read(MR, 4, "R3 line1");
    line_dw = 0;  run_read(MR, 4, "R3 line0");
    line_dw = 8;
  endtask

  task automatic t_single;
    max_sel = 3'd6;
    pol_mr = 2'b10; pref_hit = 0; run_read(MR, 4, "R4 miss");
    pref_hit = 1;
    pol_mr = 2'b01; run_read(MR, 4, "R4 mr 01");
    pol_mrl = 2'b11; run_read(MRL, 4, "R4 mrl 11");
    pol_mrm = 2'b11; run_read(MRM, 4, "R4 mrm 11");
    pol_mrm = 2'b01; run_read(MRM, 4, "R4 mrm 01");
    pol_mr = 2'b11; run_read(MR, 4, "R5 mr first dword");
  endtask

  task automatic t_pcix;
    pcix_mode = 1; pol_mrm = 2'b10;
    pulse_start(MRM);
    chk("R6 no req in pcix", req_valid, 0);
    chk("R6 idle in pcix", active, 0);
    pcix_mode = 0;
  endtask

  task automatic t_ignore;
    int stops_ok = 1;
    pulse_start(MWR);
    chk("R9 non-read no req", req_valid, 0);
    chk("R9 non-read idle", active, 0);
    pol_mr = 2'b00; line_dw = 4;
    pulse_start(MR);
    chk("R9 req", req_bytes, 16);
    beat = 1; @(negedge clk); beat = 0;
    pol_mrm = 2'b10; max_sel = 3'd6;
    pulse_start(MRM);
    chk("R9 busy start no req", req_valid, 0);
    chk("R9 busy length kept", req_bytes, 16);
    for (int i = 0; i < 3; i++) begin
      beat = 1; #1;
      if (stop !== (i == 2)) stops_ok = 0;
      @(negedge clk);
    end
    beat = 0; #1;
    chk("R9 count unchanged", stops_ok, 1);
    chk("R9 ends", active, 0);
  endtask

  initial begin
    #1;
    t_reset;
    #20 rst_n = 1;
    t_max_decode;
    t_cmd_select;
    t_line;
    t_single;
    t_pcix;
    t_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule